// File: doc/BRIEF.md
# Multiplexed Input Matrix Scanner

This block reads a grid of digital contacts wired as a number of banks that share eight physical input lines. It raises one select output per bank, one bank at a time. It holds that select for a dwell period so the shared lines can settle. On the final cycle of the dwell it captures the eight lines into the row of a result table that belongs to the active bank. The banks are visited in order, from the first to the last configured one, and the cycle repeats for as long as the enable input stays high.

The number of banks in use can be set at run time to any value from 2 to the build-time maximum. A mode input picks one of two dwell lengths, a normal one and a fast one of half the length. A sticky done flag tells downstream logic that every row of the table has been filled at least once since the scanner was last enabled. Dropping enable parks the scanner: all selects go low, the flag clears, and the table keeps its last contents.

Top module: `matrix_scanner`

## Requirements
- R1: After a synchronous reset, every select output is 0, every table bit is 0 and the done flag is 0.
- R2: While scanning, at most one bit of `bank_sel` is high. Bank b is selected by bit b. Banks follow the order 0, 1, …, n-1 and then return to 0.
- R3: Each bank stays selected for `DWELL_NORMAL` cycles when `fast_mode` is 0 and for `DWELL_FAST` cycles when it is 1. The mode is evaluated in every cycle. If a switch to the shorter dwell finds the bank already past it, the scanner moves to the next bank at the following edge.
- R4: On the last dwell cycle of bank b, `lines_in[i]` is stored into `table_out[b*LINES + i]`, and the table is updated at the same edge as the select advances. Other rows are left unchanged.
- R5: `scan_done` rises at the edge that finishes the dwell of bank n-1 on the first pass, and it stays high while `enable` remains high.
- R6: At the first edge that samples `enable` low, all selects go to 0, `scan_done` goes to 0 and the bank position returns to 0. The table holds its contents for as long as `enable` is low.
- R7: The first edge that samples `enable` high selects bank 0 and latches the bank count. A value of `bank_count` that changes in the middle of a pass takes effect only at the start of the next pass, and it does not clear `scan_done`.
- R8: A `bank_count` value below 2 is treated as 2, and a value above `MAX_BANKS` is treated as `MAX_BANKS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Scan run control; must be held high to scan |
| bank_count | input | CNT_W (4) | Requested number of banks, clamped to 2..MAX_BANKS |
| fast_mode | input | 1 | 1 selects the short dwell, 0 the normal dwell |
| lines_in | input | LINES (8) | Shared input lines of the matrix |
| bank_sel | output | MAX_BANKS (8) | One-hot registered bank select outputs |
| table_out | output | MAX_BANKS*LINES (64) | Registered result table, row b at bits b*LINES upward |
| scan_done | output | 1 | Sticky flag set after the first full pass |

## Verification
The bench goes after the cycle where a bank hands over to the next one. An off-by-one dwell counter would hold a select for one cycle too many or too few. Capturing a cycle early or late would store the wrong line values, because the lines change every cycle. The bench changes the bank count in the middle of a pass and feeds out-of-range counts. A design that applies the new count at once would skip banks or wrap early, and a missing clamp would select banks that do not exist. It toggles the dwell mode in the middle of a dwell, where a design that compares for equality would overrun the count. It also drops enable, where a design that clears the table or leaves the done flag set would be caught.

// File: rtl/mscan_pkg.sv
package mscan_pkg;

  // Clamp a requested bank count into the legal range 2..maxb.
  function automatic int unsigned clamp_banks(input int unsigned req,
                                              input int unsigned maxb);
    if (req < 2)
      return 2;
    else if (req > maxb)
      return maxb;
    else
      return req;
  endfunction

endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import mscan_pkg::*;
#(
  parameter int MAX_BANKS    = 8,
  parameter int DWELL_NORMAL = 20,
  parameter int DWELL_FAST   = 10,
  parameter int CNT_W        = 4,
  parameter int IDX_W        = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 fast_mode,
  input  logic [CNT_W-1:0]     bank_count,
  output logic [MAX_BANKS-1:0] bank_sel,
  output logic                 sample_en,
  output logic [IDX_W-1:0]     sample_row,
  output logic                 scan_done
);

  localparam int DMAX = (DWELL_NORMAL > DWELL_FAST) ? DWELL_NORMAL : DWELL_FAST;
  localparam int DCW  = $clog2(DMAX + 1);

  logic                 running;
  logic [IDX_W-1:0]     idx;
  logic [DCW-1:0]       cnt;
  logic [CNT_W-1:0]     active_n;
  logic [CNT_W-1:0]     clamped;
  logic [DCW-1:0]       dwell_m1;
  logic                 at_end;
  logic                 wrap;
  logic [IDX_W-1:0]     nxt_idx;
  logic [MAX_BANKS-1:0] nxt_sel;

  always_comb begin
    clamped  = CNT_W'(clamp_banks(int'(bank_count), MAX_BANKS));
    dwell_m1 = fast_mode ? DCW'(DWELL_FAST - 1) : DCW'(DWELL_NORMAL - 1);
    at_end   = running && (cnt >= dwell_m1);
    wrap     = (int'(idx) + 1) >= int'(active_n);
    nxt_idx  = wrap ? '0 : idx + 1'b1;
  end

  // one-hot decode of the next bank position
  for (genvar k = 0; k < MAX_BANKS; k++) begin : g_dec
    assign nxt_sel[k] = (int'(nxt_idx) == k);
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      running   <= 1'b0;
      idx       <= '0;
      cnt       <= '0;
      bank_sel  <= '0;
      scan_done <= 1'b0;
      active_n  <= CNT_W'(2);
    end else if (!running) begin
      running  <= 1'b1;
      idx      <= '0;
      cnt      <= '0;
      bank_sel <= MAX_BANKS'(1);
      active_n <= clamped;
    end else if (at_end) begin
      cnt      <= '0;
      idx      <= nxt_idx;
      bank_sel <= nxt_sel;
      if (wrap) begin
        scan_done <= 1'b1;
        active_n  <= clamped;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sample_en  = enable && at_end;
  assign sample_row = idx;

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_sel));

  assert_sel_follows_pos_R2: assert property (@(posedge clk) disable iff (rst)
    running |-> bank_sel[idx]);

  assert_dwell_bound_R3: assert property (@(posedge clk) disable iff (rst)
    running |-> (int'(cnt) < DMAX));

  assert_pos_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    running |-> (int'(idx) < int'(active_n) && active_n >= 2
                 && int'(active_n) <= MAX_BANKS));

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (enable && scan_done) |=> scan_done);

  assert_off_parks_R6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (bank_sel == '0 && !scan_done));

endmodule

// File: rtl/result_table.sv
module result_table #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [IDX_W-1:0]     wrow,
  input  logic [COLS-1:0]      wdata,
  output logic [ROWS*COLS-1:0] flat
);

  // Every row is visible at once, so the rows are plain registers
  // written one row per cycle.
  logic [COLS-1:0] rows [ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) rows[r] <= '0;
    end else if (we) begin
      rows[wrow] <= wdata;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_flat
    assign flat[r*COLS +: COLS] = rows[r];
  end

endmodule

// File: rtl/matrix_scanner.sv
module matrix_scanner #(
  parameter int MAX_BANKS    = 8,
  parameter int LINES        = 8,
  parameter int DWELL_NORMAL = 20,
  parameter int DWELL_FAST   = 10,
  parameter int CNT_W        = $clog2(MAX_BANKS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enable,
  input  logic [CNT_W-1:0]           bank_count,
  input  logic                       fast_mode,
  input  logic [LINES-1:0]           lines_in,
  output logic [MAX_BANKS-1:0]       bank_sel,
  output logic [MAX_BANKS*LINES-1:0] table_out,
  output logic                       scan_done
);

  localparam int IDX_W = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1;

  logic             sample_en;
  logic [IDX_W-1:0] sample_row;

  scan_seq #(
    .MAX_BANKS   (MAX_BANKS),
    .DWELL_NORMAL(DWELL_NORMAL),
    .DWELL_FAST  (DWELL_FAST),
    .CNT_W       (CNT_W),
    .IDX_W       (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .fast_mode (fast_mode),
    .bank_count(bank_count),
    .bank_sel  (bank_sel),
    .sample_en (sample_en),
    .sample_row(sample_row),
    .scan_done (scan_done)
  );

  result_table #(
    .ROWS (MAX_BANKS),
    .COLS (LINES),
    .IDX_W(IDX_W)
  ) u_tab (
    .clk  (clk),
    .rst  (rst),
    .we   (sample_en),
    .wrow (sample_row),
    .wdata(lines_in),
    .flat (table_out)
  );

  assert_table_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(table_out));

  assert_capture_with_sel_R4: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> bank_sel[sample_row]);

endmodule

// File: tb/sim_matrix_scanner.sv
module sim_matrix_scanner;

  localparam int PERIOD = 10;
  localparam int MAXB   = 8;
  localparam int LN     = 8;
  localparam int DN     = 20;
  localparam int DF     = 10;

  logic           clk = 1'b0;
  logic           rst;
  logic           enable;
  logic [3:0]     bank_count;
  logic           fast_mode;
  logic [LN-1:0]  lines_in;
  logic [MAXB-1:0]    bank_sel;
  logic [MAXB*LN-1:0] table_out;
  logic           scan_done;

  int vectors = 0;
  int misses  = 0;
  string phase = "R1";

  always #(PERIOD/2) clk = ~clk;

  matrix_scanner #(
    .MAX_BANKS(MAXB), .LINES(LN), .DWELL_NORMAL(DN), .DWELL_FAST(DF)
  ) u0 (
    .clk(clk), .rst(rst), .enable(enable), .bank_count(bank_count),
    .fast_mode(fast_mode), .lines_in(lines_in), .bank_sel(bank_sel),
    .table_out(table_out), .scan_done(scan_done)
  );

  // ---------------- behavioural reference ----------------
  bit              m_run;
  int              m_pos, m_el, m_n;
  logic [MAXB-1:0] m_sel;
  logic [MAXB*LN-1:0] m_tab;
  logic            m_done;

  function automatic int legal_n(input int req);
    if (req < 2) return 2;
    if (req > MAXB) return MAXB;
    return req;
  endfunction

  always @(posedge clk) begin
    if (rst || !enable) begin
      m_run = 0; m_pos = 0; m_el = 0; m_sel = '0; m_done = 1'b0;
      if (rst) m_tab = '0;
    end else if (!m_run) begin
      m_run = 1; m_pos = 0; m_el = 0; m_n = legal_n(int'(bank_count));
      m_sel = MAXB'(1);
    end else begin
      int d;
      d = fast_mode ? DF : DN;
      m_el++;
      if (m_el >= d) begin
        m_tab[m_pos*LN +: LN] = lines_in;
        m_el = 0;
        if (m_pos == m_n - 1) begin
          m_pos = 0; m_done = 1'b1; m_n = legal_n(int'(bank_count));
        end else begin
          m_pos++;
        end
        m_sel = MAXB'(1) << m_pos;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s (phase %s) t=%0t actual=%h expected=%h",
               tag, phase, $time, act, exp);
    end
  endtask

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst === 1'b0 || phase == "R1") begin
      check("R2 bank_sel", 64'(bank_sel), 64'(m_sel));
      check("R4 table_out", 64'(table_out), 64'(m_tab));
      check("R5 scan_done", 64'(scan_done), 64'(m_done));
    end
    lines_in <= LN'($urandom);
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; enable = 1'b0; bank_count = 4'd3; fast_mode = 1'b0;
    lines_in = '0;
    m_tab = '0; m_sel = '0; m_done = 1'b0; m_n = 2;
    run(3);
    // R1: reset state compared in the cycles above
    rst = 1'b0;
    run(2);
    // R7, R2, R3, R4, R5: three banks, normal dwell
    phase = "R7"; enable = 1'b1; run(250);
    // R3: fast dwell, four banks (takes effect at next pass)
    phase = "R3"; fast_mode = 1'b1; bank_count = 4'd4; run(150);
    // R7: count changed in mid pass
    phase = "R7"; fast_mode = 1'b0; run(27); bank_count = 4'd8; run(400);
    // R6: disable, table must hold and flag clear
    phase = "R6"; enable = 1'b0; run(12);
    // R8: clamp below range
    phase = "R8"; bank_count = 4'd0; enable = 1'b1; run(120);
    // R8: clamp above range
    bank_count = 4'd15; run(400);
    // R3: mode toggled in mid dwell
    phase = "R3";
    for (int k = 0; k < 10; k++) begin
      fast_mode = ~fast_mode; run(13 + k * 3);
    end
    // R6: short enable pulses
    phase = "R6";
    for (int k = 0; k < 4; k++) begin
      enable = 1'b0; run(2); enable = 1'b1; run(5 + k * 7);
    end
    // R1: reset in the middle of a scan
    phase = "R1"; rst = 1'b1; run(2); rst = 1'b0; phase = "R5"; run(300);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule